// File: doc/BRIEF.md
# True Random Number Generator Register Front-End

This block is the register-mapped control and status logic of a standalone random number generator. It sits on a 32-bit APB-style bus inside a 0x200-byte window. Software writes a command code to start a generation or a reseed. It polls a status word, or waits for a level-high interrupt, and then reads up to eight 32-bit result words. Once reset is released, the block seeds itself. After each generation it counts 16-byte output requests, and when a programmable quota is reached it reseeds without being asked.

The physical noise source is replaced by a pseudo-random chunk source. That source delivers `CHUNK_BITS` new bits every `CHUNK_CYCLES` clock cycles, and it restarts its chunk timing each time an operation begins. A wide (256-bit) result or a seeding pass needs ceil(256/CHUNK_BITS) chunks. A narrow (128-bit) result needs ceil(128/CHUNK_BITS) chunks. With the defaults of 56 bits and 1024 cycles these are 5 and 3 chunks.

Top module: `trng_regs`

## Requirements
- R1: During and after reset the block performs an initial seeding. While seeding, status (offset 0x04) shows bit 31 set and bit 9 clear. After 5 chunk periods, bit 9 (seeded) is set, bit 31 is clear and interrupt-status bit 1 (seed done) is set. Mode and interrupt-enable read zero after reset.
- R2: The command register (0x00) decodes bits [1:0]. Code 1 starts a generation and sets status bit 30. Code 2 starts a reseed and sets status bit 31. Code 0 changes nothing. Reading 0x00 returns the code of the running operation, or 0 when idle.
- R3: A generation started in wide mode completes exactly 5 chunk periods after the write edge, and one started in narrow mode completes after 3. On completion, interrupt-status bit 0 is set and status returns to seeded only.
- R4: The mode register (0x08) bit 3 selects wide (1) or narrow (0) output. Result words are read at 0x20 to 0x3C, with word k at 0x20+4k. A wide result fills all eight words. A narrow result fills 0x20 to 0x2C, and 0x30 to 0x3C read zero. Each generation gives new data.
- R5: Interrupt-status (0x14) bits are cleared by writing 1 to them. Bit 0 is set on generation done even when interrupts are disabled.
- R6: The interrupt output equals enable bit 31 AND ((enable bit 0 AND status bit 0) OR (enable bit 1 AND status bit 1)), with the enables at 0x10.
- R7: The register at 0x60 holds a quota in 16-byte units. A wide result counts 2 units and a narrow result counts 1. When a completed generation brings the count to the quota or above, the block starts a reseed at once: status bit 31 is set and bit 30 is clear. Any reseed clears the count, and a quota of 0 disables the feature.
- R8: Offset 0xF0 reads 0x000046BC, and writes to it have no effect.
- R9: Generate or reseed commands written while an operation runs are ignored. The running operation keeps its timing and its kind.
- R10: Reads of unmapped offsets return zero, and writes to them are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| psel_i | input | 1 | Bus select |
| penable_i | input | 1 | Bus access phase |
| pwrite_i | input | 1 | Bus write (1) or read (0) |
| paddr_i | input | 9 | Byte offset within the window |
| pwdata_i | input | 32 | Write data |
| prdata_o | output | 32 | Read data, combinational on offset |
| irq_o | output | 1 | Level-high interrupt |

## Verification
The automatic reseed is the hardest state to reach from the ports. It happens only when a generation completes while the request count has reached the quota, and it appears only as status bit 31 rising with no command written. The stimulus first clears the count with a manual reseed and programs a quota of 3. It then runs one wide and one narrow generation and reads status right after the second completion. Completion times are measured in clock cycles from the command's write edge to the interrupt rising, including the case where extra commands arrive during the operation.

// File: rtl/trng_pkg.sv
package trng_pkg;
  localparam int unsigned BUS_AW = 9;
  localparam int unsigned BUS_DW = 32;

  localparam logic [BUS_AW-1:0] OFF_CMD   = 9'h000;
  localparam logic [BUS_AW-1:0] OFF_STAT  = 9'h004;
  localparam logic [BUS_AW-1:0] OFF_MODE  = 9'h008;
  localparam logic [BUS_AW-1:0] OFF_IEN   = 9'h010;
  localparam logic [BUS_AW-1:0] OFF_IST   = 9'h014;
  localparam logic [BUS_AW-1:0] OFF_DATA  = 9'h020;
  localparam logic [BUS_AW-1:0] DATA_MASK = 9'h01C;
  localparam logic [BUS_AW-1:0] OFF_QUOTA = 9'h060;
  localparam logic [BUS_AW-1:0] OFF_VER   = 9'h0F0;

  localparam logic [BUS_DW-1:0] VER_CODE = 32'h0000_46BC;

  localparam int unsigned ST_SEEDED = 9;
  localparam int unsigned ST_GEN    = 30;
  localparam int unsigned ST_RSD    = 31;
  localparam int unsigned MODE_WIDE = 3;
  localparam int unsigned IE_GLBL   = 31;
  localparam int unsigned IE_SEED   = 1;
  localparam int unsigned IE_RDY    = 0;

  localparam logic [1:0] CMD_NOP = 2'd0;
  localparam logic [1:0] CMD_GEN = 2'd1;
  localparam logic [1:0] CMD_RSD = 2'd2;

  typedef enum logic [1:0] {PH_SEED, PH_IDLE, PH_GEN, PH_RSD} phase_e;
endpackage

// File: rtl/trng_chunk_src.sv
module trng_chunk_src #(
  parameter int unsigned CHUNK_BITS   = 56,
  parameter int unsigned CHUNK_CYCLES = 1024
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run_i,
  output logic [CHUNK_BITS-1:0] chunk_o,
  output logic                  vld_o
);
  localparam int unsigned TW = (CHUNK_CYCLES > 1) ? $clog2(CHUNK_CYCLES) : 1;
  localparam logic [TW-1:0] TLAST = TW'(CHUNK_CYCLES - 1);

  logic [63:0] lfsr_q, lfsr_d;
  logic [TW-1:0] tick_q, tick_d;

  always_comb begin
    lfsr_d = {lfsr_q[62:0], lfsr_q[63] ^ lfsr_q[62] ^ lfsr_q[60] ^ lfsr_q[59]};
    if (!run_i)               tick_d = '0;
    else if (tick_q == TLAST) tick_d = '0;
    else                      tick_d = tick_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q <= 64'h9E37_79B9_7F4A_7C15;
      tick_q <= '0;
    end else begin
      lfsr_q <= lfsr_d;
      tick_q <= tick_d;
    end
  end

  assign chunk_o = lfsr_q[CHUNK_BITS-1:0];
  assign vld_o   = run_i && (tick_q == TLAST);
endmodule

// File: rtl/trng_outbuf.sv
module trng_outbuf #(
  parameter int unsigned CHUNK_BITS = 56,
  parameter int unsigned OUT_BITS   = 256
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CHUNK_BITS-1:0] chunk_i,
  input  logic                  vld_i,
  input  logic                  cap_i,
  input  logic                  wide_i,
  output logic [OUT_BITS-1:0]   data_o
);
  localparam int unsigned HALF = OUT_BITS / 2;

  logic [OUT_BITS-1:0] pool_q, pool_d, data_q;

  assign pool_d = {pool_q[OUT_BITS-CHUNK_BITS-1:0], chunk_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pool_q <= '0;
    else if (vld_i) pool_q <= pool_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_q <= '0;
    else if (cap_i)  data_q <= wide_i ? pool_d : {{HALF{1'b0}}, pool_d[HALF-1:0]};
  end

  assign data_o = data_q;
endmodule

// File: rtl/trng_seq.sv
module trng_seq
  import trng_pkg::*;
#(
  parameter int unsigned CHUNK_BITS = 56,
  parameter int unsigned OUT_BITS   = 256,
  parameter int unsigned RQ_W       = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_gen_i,
  input  logic            cmd_rsd_i,
  input  logic            wide_i,
  input  logic [RQ_W-1:0] quota_i,
  input  logic            chunk_vld_i,
  output logic            run_o,
  output logic            gen_o,
  output logic            rsd_o,
  output logic            seeded_o,
  output logic            wide_o,
  output logic            gen_done_o,
  output logic            seed_done_o
);
  localparam int unsigned CH_WIDE   = (OUT_BITS + CHUNK_BITS - 1) / CHUNK_BITS;
  localparam int unsigned CH_NARROW = (OUT_BITS / 2 + CHUNK_BITS - 1) / CHUNK_BITS;
  localparam int unsigned CW        = $clog2(CH_WIDE + 1);
  localparam logic [CW-1:0] LAST_W  = CW'(CH_WIDE - 1);
  localparam logic [CW-1:0] LAST_N  = CW'(CH_NARROW - 1);

  phase_e          ph_q, ph_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [RQ_W-1:0] req_q, req_d;
  logic            wide_q, wide_d, seeded_q;
  logic [RQ_W:0]   req_sum;
  logic            quota_hit;

  assign req_sum   = {1'b0, req_q} + (wide_q ? (RQ_W+1)'(2) : (RQ_W+1)'(1));
  assign quota_hit = (quota_i != '0) && (req_sum >= {1'b0, quota_i});

  always_comb begin
    ph_d        = ph_q;
    cnt_d       = cnt_q;
    req_d       = req_q;
    wide_d      = wide_q;
    gen_done_o  = 1'b0;
    seed_done_o = 1'b0;
    unique case (ph_q)
      PH_SEED, PH_RSD: if (chunk_vld_i) begin
        if (cnt_q == LAST_W) begin
          ph_d        = PH_IDLE;
          cnt_d       = '0;
          seed_done_o = 1'b1;
        end else cnt_d = cnt_q + 1'b1;
      end
      PH_IDLE: begin
        if (cmd_gen_i) begin
          ph_d   = PH_GEN;
          wide_d = wide_i;
        end else if (cmd_rsd_i) begin
          ph_d  = PH_RSD;
          req_d = '0;
        end
      end
      PH_GEN: if (chunk_vld_i) begin
        if (cnt_q == (wide_q ? LAST_W : LAST_N)) begin
          gen_done_o = 1'b1;
          cnt_d      = '0;
          if (quota_hit) begin
            ph_d  = PH_RSD;
            req_d = '0;
          end else begin
            ph_d  = PH_IDLE;
            req_d = req_sum[RQ_W-1:0];
          end
        end else cnt_d = cnt_q + 1'b1;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= PH_SEED;
      cnt_q    <= '0;
      req_q    <= '0;
      wide_q   <= 1'b0;
      seeded_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      req_q  <= req_d;
      wide_q <= wide_d;
      if (seed_done_o) seeded_q <= 1'b1;
    end
  end

  assign run_o    = (ph_q != PH_IDLE);
  assign gen_o    = (ph_q == PH_GEN);
  assign rsd_o    = (ph_q == PH_RSD) || (ph_q == PH_SEED);
  assign seeded_o = seeded_q;
  assign wide_o   = wide_q;
endmodule

// File: rtl/trng_regs.sv
module trng_regs
  import trng_pkg::*;
#(
  parameter int unsigned CHUNK_BITS   = 56,
  parameter int unsigned CHUNK_CYCLES = 1024,
  parameter int unsigned OUT_WORDS    = 8,
  parameter int unsigned RQ_W         = 32
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [BUS_AW-1:0] paddr_i,
  input  logic [BUS_DW-1:0] pwdata_i,
  output logic [BUS_DW-1:0] prdata_o,
  output logic              irq_o
);
  localparam int unsigned OUT_BITS = OUT_WORDS * BUS_DW;
  localparam int unsigned WIX_W    = $clog2(OUT_WORDS);

  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  logic wr_en, is_data;
  logic [WIX_W-1:0] wix;
  assign wr_en   = psel_i && penable_i && pwrite_i;
  assign is_data = ((paddr_i & ~DATA_MASK) == OFF_DATA);
  assign wix     = paddr_i[WIX_W+1:2];

  logic wide_cfg_q, ie_glbl_q, ie_seed_q, ie_rdy_q;
  logic [1:0] istat_q, istat_d;
  logic [RQ_W-1:0] quota_q;

  logic run, busy_gen, busy_rsd, seeded, wide_act, gen_done, seed_done;
  logic cmd_gen, cmd_rsd, chunk_vld;
  logic [CHUNK_BITS-1:0] chunk;
  logic [OUT_BITS-1:0] dout;

  assign cmd_gen = wr_en && (paddr_i == OFF_CMD) && (pwdata_i[1:0] == CMD_GEN);
  assign cmd_rsd = wr_en && (paddr_i == OFF_CMD) && (pwdata_i[1:0] == CMD_RSD);

  trng_chunk_src #(.CHUNK_BITS(CHUNK_BITS), .CHUNK_CYCLES(CHUNK_CYCLES)) u_src (
    .clk(clk), .rst_n(rst_n), .run_i(run), .chunk_o(chunk), .vld_o(chunk_vld)
  );

  trng_seq #(.CHUNK_BITS(CHUNK_BITS), .OUT_BITS(OUT_BITS), .RQ_W(RQ_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_gen_i(cmd_gen), .cmd_rsd_i(cmd_rsd),
    .wide_i(wide_cfg_q), .quota_i(quota_q), .chunk_vld_i(chunk_vld),
    .run_o(run), .gen_o(busy_gen), .rsd_o(busy_rsd), .seeded_o(seeded),
    .wide_o(wide_act), .gen_done_o(gen_done), .seed_done_o(seed_done)
  );

  trng_outbuf #(.CHUNK_BITS(CHUNK_BITS), .OUT_BITS(OUT_BITS)) u_buf (
    .clk(clk), .rst_n(rst_n), .chunk_i(chunk), .vld_i(chunk_vld),
    .cap_i(gen_done), .wide_i(wide_act), .data_o(dout)
  );

  always_comb begin
    istat_d = istat_q;
    if (wr_en && (paddr_i == OFF_IST)) istat_d = istat_d & ~pwdata_i[1:0];
    istat_d = istat_d | {seed_done, gen_done};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wide_cfg_q <= 1'b0;
      ie_glbl_q  <= 1'b0;
      ie_seed_q  <= 1'b0;
      ie_rdy_q   <= 1'b0;
      istat_q    <= 2'b00;
      quota_q    <= '0;
    end else begin
      istat_q <= istat_d;
      if (wr_en && (paddr_i == OFF_MODE)) wide_cfg_q <= pwdata_i[MODE_WIDE];
      if (wr_en && (paddr_i == OFF_IEN)) begin
        ie_glbl_q <= pwdata_i[IE_GLBL];
        ie_seed_q <= pwdata_i[IE_SEED];
        ie_rdy_q  <= pwdata_i[IE_RDY];
      end
      if (wr_en && (paddr_i == OFF_QUOTA)) quota_q <= pwdata_i[RQ_W-1:0];
    end
  end

  always_comb begin
    prdata_o = '0;
    case (paddr_i)
      OFF_CMD:   prdata_o[1:0] = busy_gen ? CMD_GEN : (busy_rsd ? CMD_RSD : CMD_NOP);
      OFF_STAT: begin
        prdata_o[ST_SEEDED] = seeded;
        prdata_o[ST_GEN]    = busy_gen;
        prdata_o[ST_RSD]    = busy_rsd;
      end
      OFF_MODE:  prdata_o[MODE_WIDE] = wide_cfg_q;
      OFF_IEN: begin
        prdata_o[IE_GLBL] = ie_glbl_q;
        prdata_o[IE_SEED] = ie_seed_q;
        prdata_o[IE_RDY]  = ie_rdy_q;
      end
      OFF_IST:   prdata_o[1:0] = istat_q;
      OFF_QUOTA: prdata_o[RQ_W-1:0] = quota_q;
      OFF_VER:   prdata_o = VER_CODE;
      default:   if (is_data) prdata_o = dout[wix*BUS_DW +: BUS_DW];
    endcase
  end

  assign irq_o = ie_glbl_q && ((ie_rdy_q && istat_q[0]) || (ie_seed_q && istat_q[1]));
endmodule

// File: rtl/trng_regs_chk.sv
module trng_regs_chk
  import trng_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              psel_i,
  input logic              pwrite_i,
  input logic [BUS_AW-1:0] paddr_i,
  input logic [BUS_DW-1:0] prdata_o,
  input logic              irq_o,
  input logic              ie_glbl_q,
  input logic [1:0]        istat_q,
  input logic              gen_done,
  input logic              seeded,
  input logic              busy_gen,
  input logic              busy_rsd
);
  // R6: no interrupt without the global enable
  a_r6_irq_needs_glbl: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ie_glbl_q);
  // R3: a completed generation raises the ready flag
  a_r3_done_sets_rdy: assert property (@(posedge clk) disable iff (!rst_n)
    gen_done |=> istat_q[0]);
  // R1: seeded stays set once reached
  a_r1_seeded_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    seeded |=> seeded);
  // R2: never generating and reseeding together
  a_r2_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_gen && busy_rsd));
  // R9: a generation runs until its own completion
  a_r9_gen_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_gen && !gen_done) |=> busy_gen);
  // R8: version word is constant
  a_r8_version: assert property (@(posedge clk) disable iff (!rst_n)
    (psel_i && !pwrite_i && paddr_i == OFF_VER) |-> prdata_o == VER_CODE);
endmodule

bind trng_regs trng_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .psel_i(psel_i), .pwrite_i(pwrite_i),
  .paddr_i(paddr_i), .prdata_o(prdata_o), .irq_o(irq_o),
  .ie_glbl_q(ie_glbl_q), .istat_q(istat_q), .gen_done(gen_done),
  .seeded(seeded), .busy_gen(busy_gen), .busy_rsd(busy_rsd)
);

// File: tb/trng_regs_tb.sv
module trng_regs_tb;
  localparam int CC  = 32;
  localparam int N_W = 5;
  localparam int N_N = 3;
  localparam logic [31:0] SMASK = 32'hC000_0200;

  logic clk = 1'b0;
  logic rst_ni, psel, penable, pwrite, irq;
  logic [8:0] paddr;
  logic [31:0] pwdata, prdata;

  always #10 clk = ~clk;

  trng_regs #(.CHUNK_CYCLES(CC)) u_dut (
    .clk(clk), .rst_ni(rst_ni), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata),
    .prdata_o(prdata), .irq_o(irq)
  );

  typedef struct {
    logic [31:0] exp;
    logic [31:0] msk;
    string       tag;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  int n_run = 0, n_fail = 0, cyc = 0;
  logic sb_on = 1'b0;
  logic [31:0] w1 [8];
  logic [31:0] w2 [8];

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare scored reads against the queue
  always @(negedge clk) begin
    if (psel && penable && !pwrite && sb_on && q.size() > 0) begin
      cur = q.pop_front();
      n_run++;
      if ((prdata & cur.msk) !== cur.exp) begin
        n_fail++;
        $display("FAIL %s addr=%h actual=%h expected=%h", cur.tag, paddr, prdata & cur.msk, cur.exp);
      end
    end
  end

  task automatic bus(input logic w, input logic [8:0] a, input logic [31:0] d, output logic [31:0] r);
    @(posedge clk); #1;
    psel = 1'b1; penable = 1'b0; pwrite = w; paddr = a; pwdata = d;
    @(posedge clk); #1;
    penable = 1'b1;
    @(negedge clk);
    r = prdata;
    @(posedge clk); #1;
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    logic [31:0] r;
    sb_on = 1'b0;
    bus(1'b1, a, d, r);
  endtask

  task automatic rd_exp(input logic [8:0] a, input logic [31:0] e, input logic [31:0] m, input string tag);
    logic [31:0] r;
    exp_t it;
    it.exp = e & m; it.msk = m; it.tag = tag;
    q.push_back(it);
    sb_on = 1'b1;
    bus(1'b0, a, 32'h0, r);
    sb_on = 1'b0;
  endtask

  task automatic rd_val(input logic [8:0] a, output logic [31:0] v);
    sb_on = 1'b0;
    bus(1'b0, a, 32'h0, v);
  endtask

  task automatic chk(input string tag, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // cycles from the command edge until irq is seen
  task automatic time_irq(input int t0, output int n);
    int guard = 0;
    @(negedge clk);
    while (!irq && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    n = cyc - t0;
  endtask

  task automatic read_words(output logic [31:0] w [8]);
    for (int k = 0; k < 8; k++) rd_val(9'h020 + 9'(4 * k), w[k]);
  endtask

  initial begin
    #(200000 * 20);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int t0, n, any, diff;
    psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0;
    rst_ni = 1'b0;
    repeat (5) @(posedge clk);
    #1 rst_ni = 1'b1;

    // R1 reset state and initial seeding
    rd_exp(9'h004, 32'h8000_0000, SMASK, "R1 seeding at start");
    rd_exp(9'h008, 32'h0, 32'hFFFF_FFFF, "R1 mode reset");
    rd_exp(9'h010, 32'h0, 32'hFFFF_FFFF, "R1 ien reset");
    repeat (N_W * CC + 10) @(posedge clk);
    rd_exp(9'h004, 32'h0000_0200, 32'hFFFF_FFFF, "R1 seeded");
    rd_exp(9'h014, 32'h2, 32'h3, "R1 seed done flag");

    // R5 write-one-to-clear
    wr(9'h014, 32'h2);
    rd_exp(9'h014, 32'h0, 32'h3, "R5 w1c");

    // R8 version
    rd_exp(9'h0F0, 32'h0000_46BC, 32'hFFFF_FFFF, "R8 version");
    wr(9'h0F0, 32'h0);
    rd_exp(9'h0F0, 32'h0000_46BC, 32'hFFFF_FFFF, "R8 version after write");

    // R10 unmapped
    wr(9'h050, 32'hFFFF_FFFF);
    rd_exp(9'h050, 32'h0, 32'hFFFF_FFFF, "R10 unmapped write dropped");
    rd_exp(9'h01C, 32'h0, 32'hFFFF_FFFF, "R10 unmapped 0x1C");
    rd_exp(9'h1FC, 32'h0, 32'hFFFF_FFFF, "R10 unmapped 0x1FC");

    // R2 idle command has no effect
    wr(9'h000, 32'h0);
    rd_exp(9'h004, 32'h0000_0200, 32'hFFFF_FFFF, "R2 nop status");
    rd_exp(9'h000, 32'h0, 32'hFFFF_FFFF, "R2 nop cmd readback");

    // R6 enable readback and quiet irq
    wr(9'h010, 32'h8000_0001);
    rd_exp(9'h010, 32'h8000_0001, 32'hFFFF_FFFF, "R6 ien readback");
    chk("R6 irq low without flag", irq, 0);

    // R3 wide generation timing, R2 status during generation
    wr(9'h008, 32'h8);
    wr(9'h000, 32'h1);
    t0 = cyc;
    rd_exp(9'h004, 32'h4000_0200, 32'hFFFF_FFFF, "R2 generating status");
    rd_exp(9'h000, 32'h1, 32'hFFFF_FFFF, "R2 gen cmd readback");
    time_irq(t0, n);
    chk("R3 wide latency", n, N_W * CC);
    rd_exp(9'h004, 32'h0000_0200, 32'hFFFF_FFFF, "R3 ready after gen");
    rd_exp(9'h014, 32'h1, 32'h3, "R3 rdy flag");
    read_words(w1);
    any = 0;
    for (int k = 4; k < 8; k++) if (w1[k] != 0) any = 1;
    chk("R4 wide fills upper words", any, 1);

    // R6 gating
    chk("R6 irq high", irq, 1);
    wr(9'h010, 32'h0000_0001);
    chk("R6 irq off without global", irq, 0);
    wr(9'h010, 32'h8000_0001);
    wr(9'h014, 32'h1);
    chk("R5 irq low after clear", irq, 0);

    // R9 commands during generation are ignored
    wr(9'h000, 32'h1);
    t0 = cyc;
    repeat (10) @(posedge clk);
    wr(9'h000, 32'h1);
    wr(9'h000, 32'h2);
    time_irq(t0, n);
    chk("R9 timing kept", n, N_W * CC);
    rd_exp(9'h004, 32'h0000_0200, 32'hFFFF_FFFF, "R9 no reseed started");
    read_words(w2);
    diff = 0;
    for (int k = 0; k < 8; k++) if (w2[k] != w1[k]) diff = 1;
    chk("R4 new data per generation", diff, 1);

    // R4 narrow generation
    wr(9'h014, 32'h1);
    wr(9'h008, 32'h0);
    wr(9'h000, 32'h1);
    t0 = cyc;
    time_irq(t0, n);
    chk("R3 narrow latency", n, N_N * CC);
    for (int k = 4; k < 8; k++)
      rd_exp(9'h020 + 9'(4 * k), 32'h0, 32'hFFFF_FFFF, "R4 narrow upper zero");
    read_words(w1);
    chk("R4 narrow lower filled", (w1[0] | w1[1] | w1[2] | w1[3]) != 0, 1);

    // R2 manual reseed, clears request count
    wr(9'h014, 32'h3);
    wr(9'h010, 32'h8000_0002);
    wr(9'h000, 32'h2);
    t0 = cyc;
    rd_exp(9'h004, 32'h8000_0200, 32'hFFFF_FFFF, "R2 reseeding status");
    time_irq(t0, n);
    chk("R2 reseed latency", n, N_W * CC);

    // R7 automatic reseed
    wr(9'h014, 32'h3);
    wr(9'h060, 32'h3);
    rd_exp(9'h060, 32'h3, 32'hFFFF_FFFF, "R7 quota readback");
    wr(9'h010, 32'h8000_0001);
    wr(9'h008, 32'h8);
    wr(9'h000, 32'h1);
    t0 = cyc;
    time_irq(t0, n);
    rd_exp(9'h004, 32'h0000_0200, 32'hFFFF_FFFF, "R7 below quota no reseed");
    wr(9'h014, 32'h3);
    wr(9'h008, 32'h0);
    wr(9'h000, 32'h1);
    t0 = cyc;
    time_irq(t0, n);
    rd_exp(9'h004, 32'h8000_0200, 32'hFFFF_FFFF, "R7 auto reseed running");
    repeat (N_W * CC + 10) @(posedge clk);
    rd_exp(9'h004, 32'h0000_0200, 32'hFFFF_FFFF, "R7 ready after auto reseed");
    rd_exp(9'h014, 32'h2, 32'h2, "R7 seed done after auto reseed");

    repeat (4) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule